// File: doc/BRIEF.md
# Page Write Buffer and Commit

This block gathers the data bytes of one serial-memory write transaction into a small page buffer and commits them to a 512 x 8 storage array after the transaction ends with a Stop. The slave controller hands it a 9-bit start address, one strobe per received data byte, a Stop strobe and an abort strobe. The abort strobe is used when a transaction ends without a Stop, for example on a repeated Start. The block then runs a self-timed write cycle and holds `busy` for its whole length. The slave controller uses `busy` to withhold acknowledges while the cycle runs.

The upper five address bits select a 16-byte page, and only the four low bits advance as bytes arrive. A long burst therefore wraps inside its page and overwrites its own earlier bytes. Per-position valid flags make sure that only positions loaded in the current transaction reach the array. The protect pin is sampled at the Stop. When it is high it blocks any commit to the upper half of the array, but the full timed busy period still runs. The array is a plain synchronous RAM with one registered read port for the read path.

The controller has four states. In IDLE no transaction is open. ADDRESSED means a start address is held but no data byte has arrived. LOADING means at least one byte is buffered. In BUSY the commit walk and the timed cycle are running. The transitions are as follows:
- An address load moves IDLE to ADDRESSED.
- From ADDRESSED, a data byte moves to LOADING, and an abort or a Stop returns to IDLE.
- From LOADING, an abort returns to IDLE, a Stop moves to BUSY, and a new address load restarts in ADDRESSED.
- BUSY returns to IDLE on the last cycle of the timed window.

Top module: `pwb_commit_top`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and the block is in IDLE.
- R2: Byte k of a transaction that starts at address A goes to buffer position (A[3:0]+k) mod 16. The commit then writes each loaded position i to address {A[8:4], i}, in ascending order of i, with `mem_wdata` equal to the byte held at that position.
- R3: When more than 16 bytes arrive before the Stop, the position wraps within the page and a later byte replaces the earlier byte at the same position.
- R4: A Stop starts a write cycle only if at least one data byte has been loaded since the last address load. A transaction that carries only an address, or that is aborted, produces no `busy` period and no array write.
- R5: `busy` rises in the cycle after the Stop strobe is accepted and stays high for exactly WRITE_CYCLES clock cycles.
- R6: The protect pin is sampled only in the Stop cycle. If it is high then and the page lies in the upper half (A[8]=1), the array is left unchanged but `busy` still lasts WRITE_CYCLES cycles.
- R7: With the protect pin low at the Stop, pages in the upper half are written. Pages in the lower half are written whatever the protect pin's level.
- R8: Only positions loaded in the current transaction are written. Valid flags are cleared at each address load, so bytes from an earlier transaction are never committed again.
- R9: Address loads, data strobes and Stops that arrive while `busy` is high are ignored. They start no second cycle and change no array location.
- R10: `rd_data` gives the array byte at `rd_addr` one clock cycle after `rd_addr` is applied.
- R11: `mem_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Strobe: start a write transaction at `addr_in` |
| addr_in | input | 9 | Start byte address of the transaction |
| data_strobe | input | 1 | Strobe: one received data byte on `data_in` |
| data_in | input | 8 | Received data byte |
| stop_strobe | input | 1 | Strobe: Stop condition seen |
| abort_strobe | input | 1 | Strobe: transaction ended without a Stop |
| wp_pin | input | 1 | Protect pin, high blocks writes to the upper half |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Registered array read data |
| mem_we | output | 1 | Array write enable during commit |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The Stop strobe is accepted at one clock edge, and `busy` is high from the next cycle for WRITE_CYCLES cycles. The commit write for buffer position i appears on `mem_we`/`mem_addr`/`mem_wdata` in busy cycle i, counting from 0, and `rd_data` follows `rd_addr` by one cycle. The bench drives all strobes and samples all outputs on falling edges. A scoreboard monitor compares every write-enable cycle against a queue of expected writes. The queue is filled, in ascending position order, before the Stop is issued. After each cycle the bench counts the falling edges with `busy` high, checks that the queue has drained, and reads the array back one cycle after setting the read address.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ADDRESSED = 2'd1,
        ST_LOADING   = 2'd2,
        ST_BUSY      = 2'd3
    } pwb_state_e;

endpackage

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0]     data_arr [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_vec;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              v_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (hit) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                d_q <= wr_data;
            end
        end

        assign data_arr[g]  = d_q;
        assign valid_vec[g] = v_q;
    end

    assign rd_data  = data_arr[rd_idx];
    assign rd_valid = valid_vec[rd_idx];

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int WRITE_CYCLES = 20000,
    parameter int PAGE_BYTES   = 16,
    localparam int IDX_W       = $clog2(PAGE_BYTES),
    localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [IDX_W-1:0] walk_idx,
    output logic             walk_active,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] WALK_C = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || last) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last        = run && (count_q == LAST_C);
    assign walk_active = run && (count_q < WALK_C);
    assign walk_idx    = count_q[IDX_W-1:0];

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/pwb_commit_top.sv
module pwb_commit_top
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 20000,
    localparam int IDX_W       = $clog2(PAGE_BYTES),
    localparam int PAGE_W      = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_strobe,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop_strobe,
    input  logic              abort_strobe,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);

    pwb_state_e state_q, state_d;

    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              wp_hold;

    logic              accept_addr;
    logic              accept_data;
    logic              commit_go;
    logic              open_txn;

    logic [IDX_W-1:0]  walk_idx;
    logic              walk_active;
    logic              cycle_last;
    logic [DATA_W-1:0] slot_data;
    logic              slot_valid;
    logic              protect;

    // Strobe acceptance: abort beats Stop, Stop beats address, address beats data.
    always_comb begin
        open_txn    = (state_q == ST_ADDRESSED) || (state_q == ST_LOADING);
        accept_addr = addr_load && !abort_strobe && !stop_strobe && (state_q != ST_BUSY);
        accept_data = data_strobe && !addr_load && !abort_strobe && !stop_strobe && open_txn;
        commit_go   = stop_strobe && !abort_strobe && (state_q == ST_LOADING);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_addr) state_d = ST_ADDRESSED;
            end
            ST_ADDRESSED: begin
                if (abort_strobe || stop_strobe) state_d = ST_IDLE;
                else if (accept_data)            state_d = ST_LOADING;
            end
            ST_LOADING: begin
                if (abort_strobe)     state_d = ST_IDLE;
                else if (commit_go)   state_d = ST_BUSY;
                else if (accept_addr) state_d = ST_ADDRESSED;
            end
            ST_BUSY: begin
                if (cycle_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Address pointer and protect sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            ptr_q   <= '0;
            wp_hold <= 1'b0;
        end else begin
            if (accept_addr) begin
                page_q <= addr_in[ADDR_W-1:IDX_W];
                ptr_q  <= addr_in[IDX_W-1:0];
            end else if (accept_data) begin
                ptr_q  <= ptr_q + 1'b1;
            end
            if (commit_go) begin
                wp_hold <= wp_pin;
            end
        end
    end

    pwb_page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept_addr),
        .wr_en    (accept_data),
        .wr_idx   (ptr_q),
        .wr_data  (data_in),
        .rd_idx   (walk_idx),
        .rd_data  (slot_data),
        .rd_valid (slot_valid)
    );

    pwb_cycle_timer #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .PAGE_BYTES   (PAGE_BYTES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (state_q == ST_BUSY),
        .walk_idx    (walk_idx),
        .walk_active (walk_active),
        .last        (cycle_last)
    );

    // Outputs
    always_comb begin
        protect   = wp_hold && page_q[PAGE_W-1];
        busy      = (state_q == ST_BUSY);
        mem_we    = busy && walk_active && slot_valid && !protect;
        mem_addr  = {page_q, walk_idx};
        mem_wdata = slot_data;
    end

    pwb_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/pwb_commit_checker.sv
module pwb_commit_checker #(
    parameter int ADDR_W       = 9,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 20000,
    localparam int IDX_W       = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_strobe,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wp_hold
);

    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R11

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_strobe)); // R4

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 32'(WRITE_CYCLES))); // R5

    AST_NO_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp_hold && mem_addr[ADDR_W-1])); // R6

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy)) |->
            (mem_addr[ADDR_W-1:IDX_W] == $past(mem_addr[ADDR_W-1:IDX_W]))); // R2

    AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy)) |->
            (mem_addr[IDX_W-1:0] > $past(mem_addr[IDX_W-1:0]))); // R2

endmodule

bind pwb_commit_top pwb_commit_checker #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_strobe (stop_strobe),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .wp_hold     (wp_hold)
);

// File: tb/tb_pwb_commit_top.sv
`timescale 1ns/1ps
module tb_pwb_commit_top;

    localparam int T_WC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [8:0] addr_in = '0;
    logic       data_strobe = 1'b0;
    logic [7:0] data_in = '0;
    logic       stop_strobe = 1'b0;
    logic       abort_strobe = 1'b0;
    logic       wp_pin = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       busy;

    always #2 clk = ~clk;

    pwb_commit_top #(.WRITE_CYCLES(T_WC)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .data_strobe(data_strobe), .data_in(data_in), .stop_strobe(stop_strobe),
        .abort_strobe(abort_strobe), .wp_pin(wp_pin), .rd_addr(rd_addr),
        .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    typedef struct packed {
        logic [8:0] a;
        logic [7:0] d;
    } wr_item_t;

    wr_item_t   exp_q [$];
    logic [7:0] model [512];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every write-enable cycle pops one expected write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            chk(busy === 1'b1, "R11 write outside busy", int'(busy), 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected write", int'(mem_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(mem_addr === it.a, "R2 write address", int'(mem_addr), int'(it.a));
                chk(mem_wdata === it.d, "R2 write data", int'(mem_wdata), int'(it.d));
            end
        end
    end

    // Loads a transaction, sets the protect pin for the Stop, queues the expected writes
    task automatic run_txn(input logic [8:0] start, input int nbytes,
                           input logic [7:0] seed, input logic wp_stop);
        logic [7:0] pbuf [16];
        bit         pv   [16];
        for (int i = 0; i < 16; i++) begin
            pv[i]   = 1'b0;
            pbuf[i] = '0;
        end
        wp_pin = ~wp_stop;
        @(negedge clk);
        addr_load = 1'b1;
        addr_in   = start;
        @(negedge clk);
        addr_load = 1'b0;
        for (int k = 0; k < nbytes; k++) begin
            int pos;
            pos = (int'(start[3:0]) + k) % 16;
            data_strobe = 1'b1;
            data_in     = seed + 8'(k);
            pbuf[pos]   = seed + 8'(k);
            pv[pos]     = 1'b1;
            @(negedge clk);
        end
        data_strobe = 1'b0;
        wp_pin      = wp_stop;
        if (nbytes > 0 && !(wp_stop && start[8])) begin
            for (int i = 0; i < 16; i++) begin
                if (pv[i]) begin
                    wr_item_t it;
                    it.a = {start[8:4], 4'(i)};
                    it.d = pbuf[i];
                    exp_q.push_back(it);
                    model[it.a] = it.d;
                end
            end
        end
        stop_strobe = 1'b1;
        @(negedge clk);
        stop_strobe = 1'b0;
    endtask

    task automatic wait_done(input int exp_len, input string tag);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        wp_pin = 1'b0;
        chk(n == exp_len, tag, n, exp_len);
        chk(exp_q.size() == 0, "R8 pending writes after cycle", exp_q.size(), 0);
    endtask

    task automatic rd_check(input logic [8:0] a, input string tag);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        chk(rd_data === model[a], tag, int'(rd_data), int'(model[a]));
    endtask

    task automatic idle_check(input string tag);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(busy === 1'b0, tag, int'(busy), 0);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(mem_we === 1'b0, "R1 mem_we after reset", int'(mem_we), 0);

        // R2 R5: three bytes in a lower page
        run_txn(9'h023, 3, 8'h41, 1'b0);
        wait_done(T_WC, "R5 busy length");
        rd_check(9'h023, "R10 readback");
        rd_check(9'h025, "R2 readback last byte");

        // R3: twenty bytes from position C wrap and overwrite
        run_txn(9'h05C, 20, 8'hA0, 1'b0);
        wait_done(T_WC, "R5 busy length wrap");
        rd_check(9'h05C, "R3 overwritten position");
        rd_check(9'h05B, "R3 wrapped tail");

        // R4: address only, then aborted transaction
        @(negedge clk); addr_load = 1'b1; addr_in = 9'h030;
        @(negedge clk); addr_load = 1'b0; stop_strobe = 1'b1;
        @(negedge clk); stop_strobe = 1'b0;
        idle_check("R4 address-only no busy");
        @(negedge clk); addr_load = 1'b1; addr_in = 9'h031;
        @(negedge clk); addr_load = 1'b0; data_strobe = 1'b1; data_in = 8'h77;
        @(negedge clk); data_strobe = 1'b0; abort_strobe = 1'b1;
        @(negedge clk); abort_strobe = 1'b0; stop_strobe = 1'b1;
        @(negedge clk); stop_strobe = 1'b0;
        idle_check("R4 aborted no busy");

        // R7: upper page with protect low at Stop, lower page with protect high at Stop
        run_txn(9'h1A0, 4, 8'h10, 1'b0);
        wait_done(T_WC, "R7 busy length upper");
        rd_check(9'h1A2, "R7 upper written");
        run_txn(9'h0A0, 2, 8'h50, 1'b1);
        wait_done(T_WC, "R7 busy length lower");
        rd_check(9'h0A1, "R7 lower written under protect");

        // R6: protected commit leaves array, keeps busy length
        run_txn(9'h1A0, 4, 8'h80, 1'b1);
        wait_done(T_WC, "R6 protected busy length");
        rd_check(9'h1A0, "R6 protected unchanged");
        rd_check(9'h1A3, "R6 protected unchanged end");

        // R8: full page, then a two-byte rewrite leaves the rest
        run_txn(9'h040, 16, 8'hC0, 1'b0);
        wait_done(T_WC, "R5 busy length full page");
        run_txn(9'h040, 2, 8'h01, 1'b0);
        wait_done(T_WC, "R5 busy length short");
        rd_check(9'h041, "R8 new byte");
        rd_check(9'h045, "R8 stale position kept");

        // R9: strobes during busy are ignored
        run_txn(9'h0F0, 1, 8'h33, 1'b0);
        wait_done(T_WC, "R5 busy length single");
        run_txn(9'h070, 2, 8'h60, 1'b0);
        addr_load = 1'b1; addr_in = 9'h0F0;
        @(negedge clk); addr_load = 1'b0; data_strobe = 1'b1; data_in = 8'h99;
        @(negedge clk); data_strobe = 1'b0; stop_strobe = 1'b1;
        @(negedge clk); stop_strobe = 1'b0;
        wait_done(T_WC - 3, "R9 busy not extended");
        idle_check("R9 no second cycle");
        rd_check(9'h0F0, "R9 location unchanged");

        summary();
        $finish;
    end

endmodule